// File: doc/BRIEF.md
# Cycle-Timed Test Interrupt Coprocessor

This block is a test-support coprocessor for exercising a processor's interrupt and stall handling in a controlled way. It holds sixteen 32-bit general registers and accepts one command per cycle while it is idle. A command is either a register write, a register read, a block load, a block store, or an operation. Operations take a cycle count from a register and use it to do one of three things: stall the requester for that many cycles, or drop the fast (FIQ) or normal (IRQ) interrupt line after that many cycles. Other operations raise either line again, or record a free-running cycle counter into a register so that software can timestamp events.

A requester presents `cmd_valid` with a command kind, a 24-bit command word and a write word. The block answers with a one-cycle `done` pulse when the command completes. `cant` rises with `done` when the command was refused. Read data comes back on `rd_data`, qualified by `rd_valid`. While `busy` is high, any command presented is dropped. Both interrupt outputs are active low.

Top module: `cyc_test_copro`

## Requirements
- R1: Kind 0 writes `wr_data` into the register selected by command bits 19:16. Kind 1 reads that register. In the cycle after acceptance, `rd_data` holds the value and `rd_valid` and `done` are high for one cycle.
- R2: Kind 2 with opcode 0 (command bits 23:20) takes N from the register selected by bits 3:0. If N > 0, `busy` is high for exactly N cycles after acceptance and `done` pulses in the first cycle with `busy` low. If N = 0, `done` pulses in the cycle after acceptance and `busy` stays low.
- R3: Opcode 1 drives `fiq_n` low and opcode 2 drives `irq_n` low, N clock edges after the accepting edge, where N is taken as in R2. With N = 0 the line is low in the cycle right after acceptance. `done` pulses in the cycle after acceptance.
- R4: Opcode 3 sets `fiq_n` high and opcode 4 sets `irq_n` high, in the cycle after acceptance. Each also cancels any countdown pending on its own line.
- R5: A new opcode 1 or 2 command reloads that line's countdown. Any countdown already pending on the same line is replaced.
- R6: Opcode 5 stores the free-running cycle counter into the register selected by bits 3:0. The value stored is the counter's value in the cycle of acceptance. The counter is 0 in the first cycle after reset, adds 1 on every clock edge, and wraps modulo 2^32.
- R7: Opcodes 6 to 15 complete with `done` and `cant` both high. So do command kinds 5 to 7. Neither changes any register or interrupt line.
- R8: Kind 3 (block load) writes `wr_data` into the register selected by bits 15:12. If bit 22 is set, the command takes a second word: `busy` is high for one cycle, and `wr_data` in that cycle goes into the next register index (mod 16). `done` pulses after the last word.
- R9: Kind 4 (block store) returns the register selected by bits 15:12 with `rd_valid`. If bit 22 is set, it also returns the next register index (mod 16) one cycle later, with `busy` high in between. `done` pulses with the last word.
- R10: A command presented while `busy` is high is ignored. It writes no register and moves no interrupt line.
- R11: After reset, `fiq_n` and `irq_n` are high; `busy`, `done`, `cant` and `rd_valid` are low; and `rd_data` is zero. Register contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_kind | input | 3 | 0 write, 1 read, 2 operation, 3 block load, 4 block store |
| cmd_word | input | 24 | Command fields: register index, opcode, operand index, block index, long flag |
| wr_data | input | DATA_W | Write word, and the second word of a long block load |
| busy | output | 1 | Stall or second transfer beat in progress |
| done | output | 1 | One-cycle completion pulse |
| cant | output | 1 | Command refused, valid with done |
| rd_valid | output | 1 | rd_data carries a read word |
| rd_data | output | DATA_W | Read word |
| fiq_n | output | 1 | Fast interrupt line, active low |
| irq_n | output | 1 | Normal interrupt line, active low |

## Verification
The assertions assume three things about the inputs. The requester may present commands while `busy` is high, and expects them to be dropped. The second word of a long block load is on `wr_data` in the cycle right after acceptance. No register is used as a stall or delay count before it has been written. The stimulus meets these assumptions as follows. It writes all sixteen registers before any other command. It keeps cycle counts small so that every countdown expires inside the run. It deliberately issues writes and interrupt commands during a stall, then reads the affected state back to show that they were dropped.

// File: rtl/cyc_test_pkg.sv
package cyc_test_pkg;
  localparam int IDX_W   = 4;
  localparam int N_LINES = 2;
  localparam int OPC_W   = 4;
  // command word field positions
  localparam int F_REG   = 16;
  localparam int F_OPC   = 20;
  localparam int F_OPR   = 0;
  localparam int F_BLK   = 12;
  localparam int F_LONG  = 22;

  typedef enum logic [2:0] {
    CK_REG_WR = 3'd0,
    CK_REG_RD = 3'd1,
    CK_OPER   = 3'd2,
    CK_BLK_LD = 3'd3,
    CK_BLK_ST = 3'd4
  } cmd_kind_e;

  localparam logic [OPC_W-1:0] OP_STALL = 4'd0;
  localparam logic [OPC_W-1:0] OP_FARM  = 4'd1;
  localparam logic [OPC_W-1:0] OP_IARM  = 4'd2;
  localparam logic [OPC_W-1:0] OP_FOFF  = 4'd3;
  localparam logic [OPC_W-1:0] OP_IOFF  = 4'd4;
  localparam logic [OPC_W-1:0] OP_STAMP = 4'd5;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_STALL = 2'd1,
    SQ_LD2   = 2'd2,
    SQ_ST2   = 2'd3
  } sq_state_e;
endpackage

// File: rtl/cyc_test_regfile.sv
module cyc_test_regfile #(
  parameter int DATA_W = 32,
  parameter int AW     = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [AW-1:0]     ra,
  output logic [DATA_W-1:0] rd
);
  // small distributed memory: one write port, asynchronous read
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd = mem[ra];
endmodule

// File: rtl/cyc_test_irq_timer.sv
module cyc_test_irq_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             clear,
  input  logic [CNT_W-1:0] count,
  output logic             line_n
);
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_n <= 1'b1;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clear) begin
      line_n <= 1'b1;
      pend_q <= 1'b0;
    end else if (arm) begin
      if (count == '0) begin
        line_n <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        pend_q <= 1'b1;
        cnt_q  <= count;
      end
    end else if (pend_q) begin
      if (cnt_q == CNT_W'(1)) begin
        line_n <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  AST_CLEAR_RAISES: assert property (@(posedge clk) disable iff (rst)
    clear |=> line_n); // R4
  AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(line_n) |-> ($past(arm) || $past(pend_q))); // R3
  AST_ZERO_ARM_NOW: assert property (@(posedge clk) disable iff (rst)
    (arm && !clear && count == '0) |=> !line_n); // R3
  AST_PEND_NONZERO: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> (cnt_q != '0)); // R5
endmodule

// File: rtl/cyc_test_seq.sv
module cyc_test_seq
  import cyc_test_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CMD_W  = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_kind,
  input  logic [CMD_W-1:0]   cmd_word,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [DATA_W-1:0]  rf_rd,
  output logic               rf_we,
  output logic [IDX_W-1:0]   rf_wa,
  output logic [DATA_W-1:0]  rf_wd,
  output logic [IDX_W-1:0]   rf_ra,
  output logic [N_LINES-1:0] arm,
  output logic [N_LINES-1:0] clr,
  output logic               busy,
  output logic               done,
  output logic               cant,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data
);
  sq_state_e         state_q;
  logic [DATA_W-1:0] wcnt_q;
  logic [DATA_W-1:0] cyc_q;
  logic [IDX_W-1:0]  blk_q;
  logic [IDX_W-1:0]  blk_nx;
  logic              accept;
  logic [OPC_W-1:0]  opc;
  logic              long_f;
  logic [IDX_W-1:0]  f_reg, f_opr, f_blk;

  assign accept = cmd_valid && (state_q == SQ_IDLE);
  assign opc    = cmd_word[F_OPC +: OPC_W];
  assign long_f = cmd_word[F_LONG];
  assign f_reg  = cmd_word[F_REG +: IDX_W];
  assign f_opr  = cmd_word[F_OPR +: IDX_W];
  assign f_blk  = cmd_word[F_BLK +: IDX_W];
  assign blk_nx = blk_q + 1'b1;

  // read address select
  always_comb begin
    rf_ra = f_reg;
    if (state_q == SQ_ST2) rf_ra = blk_nx;
    else if (cmd_kind == CK_OPER) rf_ra = f_opr;
    else if (cmd_kind == CK_BLK_ST) rf_ra = f_blk;
  end

  // write port select
  always_comb begin
    rf_we = 1'b0;
    rf_wa = f_reg;
    rf_wd = wr_data;
    if (state_q == SQ_LD2) begin
      rf_we = 1'b1;
      rf_wa = blk_nx;
    end else if (accept) begin
      if (cmd_kind == CK_REG_WR) begin
        rf_we = 1'b1;
      end else if (cmd_kind == CK_BLK_LD) begin
        rf_we = 1'b1;
        rf_wa = f_blk;
      end else if (cmd_kind == CK_OPER && opc == OP_STAMP) begin
        rf_we = 1'b1;
        rf_wa = f_opr;
        rf_wd = cyc_q;
      end
    end
  end

  // interrupt line controls: index 0 fast, index 1 normal
  always_comb begin
    arm = '0;
    clr = '0;
    if (accept && cmd_kind == CK_OPER) begin
      arm[0] = (opc == OP_FARM);
      arm[1] = (opc == OP_IARM);
      clr[0] = (opc == OP_FOFF);
      clr[1] = (opc == OP_IOFF);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_IDLE;
      wcnt_q   <= '0;
      cyc_q    <= '0;
      blk_q    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      cant     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      cyc_q    <= cyc_q + 1'b1;
      done     <= 1'b0;
      cant     <= 1'b0;
      rd_valid <= 1'b0;
      case (state_q)
        SQ_STALL: begin
          if (wcnt_q == DATA_W'(1)) begin
            state_q <= SQ_IDLE;
            busy    <= 1'b0;
            done    <= 1'b1;
          end else begin
            wcnt_q <= wcnt_q - 1'b1;
          end
        end
        SQ_LD2: begin
          state_q <= SQ_IDLE;
          busy    <= 1'b0;
          done    <= 1'b1;
        end
        SQ_ST2: begin
          rd_data  <= rf_rd;
          rd_valid <= 1'b1;
          state_q  <= SQ_IDLE;
          busy     <= 1'b0;
          done     <= 1'b1;
        end
        default: begin
          if (cmd_valid) begin
            case (cmd_kind)
              CK_REG_WR: done <= 1'b1;
              CK_REG_RD: begin
                rd_data  <= rf_rd;
                rd_valid <= 1'b1;
                done     <= 1'b1;
              end
              CK_OPER: begin
                if (opc == OP_STALL) begin
                  if (rf_rd == '0) begin
                    done <= 1'b1;
                  end else begin
                    state_q <= SQ_STALL;
                    busy    <= 1'b1;
                    wcnt_q  <= rf_rd;
                  end
                end else if (opc <= OP_STAMP) begin
                  done <= 1'b1;
                end else begin
                  done <= 1'b1;
                  cant <= 1'b1;
                end
              end
              CK_BLK_LD: begin
                blk_q <= f_blk;
                if (long_f) begin
                  state_q <= SQ_LD2;
                  busy    <= 1'b1;
                end else begin
                  done <= 1'b1;
                end
              end
              CK_BLK_ST: begin
                blk_q    <= f_blk;
                rd_data  <= rf_rd;
                rd_valid <= 1'b1;
                if (long_f) begin
                  state_q <= SQ_ST2;
                  busy    <= 1'b1;
                end else begin
                  done <= 1'b1;
                end
              end
              default: begin
                done <= 1'b1;
                cant <= 1'b1;
              end
            endcase
          end
        end
      endcase
    end
  end

  AST_STALL_ENDS: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_STALL && wcnt_q == DATA_W'(1)) |=> (done && !busy)); // R2
  AST_CANT_HAS_DONE: assert property (@(posedge clk) disable iff (rst)
    cant |-> done); // R7
  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (busy && state_q != SQ_LD2) |-> !rf_we); // R10
  AST_LINE_CTRL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arm, clr})); // R4
  AST_LONG_ONE_BEAT: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_LD2 || state_q == SQ_ST2) |=> !busy); // R8
  AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cyc_q == DATA_W'($past(cyc_q) + 1'b1))); // R6
endmodule

// File: rtl/cyc_test_copro.sv
module cyc_test_copro
  import cyc_test_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CMD_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_kind,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              cant,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              fiq_n,
  output logic              irq_n
);
  logic               rf_we;
  logic [IDX_W-1:0]   rf_wa, rf_ra;
  logic [DATA_W-1:0]  rf_wd, rf_rd;
  logic [N_LINES-1:0] arm, clr, lines_n;

  cyc_test_regfile #(.DATA_W(DATA_W), .AW(IDX_W)) u_rf (
    .clk(clk), .we(rf_we), .wa(rf_wa), .wd(rf_wd), .ra(rf_ra), .rd(rf_rd)
  );

  cyc_test_seq #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_word(cmd_word), .wr_data(wr_data), .rf_rd(rf_rd),
    .rf_we(rf_we), .rf_wa(rf_wa), .rf_wd(rf_wd), .rf_ra(rf_ra),
    .arm(arm), .clr(clr), .busy(busy), .done(done), .cant(cant),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    cyc_test_irq_timer #(.CNT_W(DATA_W)) u_tmr (
      .clk(clk), .rst(rst), .arm(arm[g]), .clear(clr[g]),
      .count(rf_rd), .line_n(lines_n[g])
    );
  end

  assign fiq_n = lines_n[0];
  assign irq_n = lines_n[1];
endmodule

// File: tb/tb_cyc_test_copro.sv
module tb_cyc_test_copro;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_kind = 3'd0;
  logic [23:0] cmd_word = 24'd0;
  logic [31:0] wr_data = 32'd0;
  logic        busy, done, cant, rd_valid, fiq_n, irq_n;
  logic [31:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_test_copro dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_word(cmd_word), .wr_data(wr_data), .busy(busy), .done(done),
    .cant(cant), .rd_valid(rd_valid), .rd_data(rd_data),
    .fiq_n(fiq_n), .irq_n(irq_n)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 0;
  string cur_req = "R11";

  // reference model state
  logic [31:0] mreg [16];
  int          m_state = 0;            // 0 idle, 1 stall, 2 load beat 2, 3 store beat 2
  logic [31:0] m_wcnt = 0, m_cyc = 0;
  logic [3:0]  m_bidx = 0;
  logic [1:0]  m_line = 2'b11, m_pend = 2'b00;
  logic [31:0] m_lcnt [2];
  logic        e_busy = 0, e_done = 0, e_cant = 0, e_rdv = 0;
  logic [31:0] e_rd = 0;

  function automatic logic [23:0] cw(int ri, int opc, int ro, int bi, bit lng);
    logic [23:0] w;
    w = '0;
    w[19:16] = 4'(ri);
    w[23:20] = 4'(opc);
    w[3:0]   = 4'(ro);
    w[15:12] = 4'(bi);
    if (lng) w[22] = 1'b1;
    return w;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic       acc;
    logic [3:0] opc, ri, ro, bi, nx;
    logic [31:0] cval;
    logic [1:0] a_l, c_l;
    acc  = cmd_valid && (m_state == 0);
    opc  = cmd_word[23:20];
    ri   = cmd_word[19:16];
    ro   = cmd_word[3:0];
    bi   = cmd_word[15:12];
    cval = mreg[ro];
    a_l = 2'b00; c_l = 2'b00;
    if (acc && cmd_kind == 3'd2) begin
      a_l[0] = (opc == 1); a_l[1] = (opc == 2);
      c_l[0] = (opc == 3); c_l[1] = (opc == 4);
    end
    for (int l = 0; l < 2; l++) begin
      if (c_l[l]) begin m_line[l] = 1; m_pend[l] = 0; end
      else if (a_l[l]) begin
        if (cval == 0) begin m_line[l] = 0; m_pend[l] = 0; end
        else begin m_pend[l] = 1; m_lcnt[l] = cval; end
      end else if (m_pend[l]) begin
        if (m_lcnt[l] == 1) begin m_line[l] = 0; m_pend[l] = 0; end
        else m_lcnt[l] = m_lcnt[l] - 1;
      end
    end
    e_done = 0; e_cant = 0; e_rdv = 0;
    nx = m_bidx + 4'd1;
    if (m_state == 1) begin
      if (m_wcnt == 1) begin m_state = 0; e_busy = 0; e_done = 1; end
      else m_wcnt = m_wcnt - 1;
    end else if (m_state == 2) begin
      mreg[nx] = wr_data; m_state = 0; e_busy = 0; e_done = 1;
    end else if (m_state == 3) begin
      e_rd = mreg[nx]; e_rdv = 1; m_state = 0; e_busy = 0; e_done = 1;
    end else if (cmd_valid) begin
      case (cmd_kind)
        3'd0: begin mreg[ri] = wr_data; e_done = 1; end
        3'd1: begin e_rd = mreg[ri]; e_rdv = 1; e_done = 1; end
        3'd2: begin
          if (opc == 0) begin
            if (cval == 0) e_done = 1;
            else begin m_state = 1; e_busy = 1; m_wcnt = cval; end
          end else if (opc <= 5) begin
            if (opc == 5) mreg[ro] = m_cyc;
            e_done = 1;
          end else begin e_done = 1; e_cant = 1; end
        end
        3'd3: begin
          mreg[bi] = wr_data; m_bidx = bi;
          if (cmd_word[22]) begin m_state = 2; e_busy = 1; end else e_done = 1;
        end
        3'd4: begin
          e_rd = mreg[bi]; e_rdv = 1; m_bidx = bi;
          if (cmd_word[22]) begin m_state = 3; e_busy = 1; end else e_done = 1;
        end
        default: begin e_done = 1; e_cant = 1; end
      endcase
    end
    m_cyc = m_cyc + 1;
  endtask

  task automatic compare_all();
    chk("busy", 32'(busy), 32'(e_busy));
    chk("done", 32'(done), 32'(e_done));
    chk("cant", 32'(cant), 32'(e_cant));
    chk("rd_valid", 32'(rd_valid), 32'(e_rdv));
    chk("rd_data", rd_data, e_rd);
    chk("fiq_n", 32'(fiq_n), 32'(m_line[0]));
    chk("irq_n", 32'(irq_n), 32'(m_line[1]));
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic issue(logic [2:0] k, logic [23:0] w, logic [31:0] d);
    cmd_valid = 1; cmd_kind = k; cmd_word = w; wr_data = d;
    step();
    cmd_valid = 0;
  endtask

  task automatic idle(int n);
    cmd_valid = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    m_lcnt[0] = 0; m_lcnt[1] = 0;
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R11";
    compare_all();
    rst = 0;

    cur_req = "R1";
    for (int i = 0; i < 16; i++) issue(3'd0, cw(i, 0, 0, 0, 0), 32'hA5000000 ^ (32'(i) * 32'h01010101));
    issue(3'd1, cw(0, 0, 0, 0, 0), 0);
    issue(3'd1, cw(15, 0, 0, 0, 0), 0);
    issue(3'd1, cw(6, 0, 0, 0, 0), 0);
    idle(1);
    // counts used below
    issue(3'd0, cw(3, 0, 0, 0, 0), 32'd5);
    issue(3'd0, cw(4, 0, 0, 0, 0), 32'd0);
    issue(3'd0, cw(5, 0, 0, 0, 0), 32'd4);
    issue(3'd0, cw(8, 0, 0, 0, 0), 32'd6);
    issue(3'd0, cw(10, 0, 0, 0, 0), 32'd1);

    cur_req = "R2";
    issue(3'd2, cw(0, 0, 3, 0, 0), 0);
    idle(6);
    issue(3'd2, cw(0, 0, 4, 0, 0), 0);
    idle(1);
    issue(3'd2, cw(0, 0, 10, 0, 0), 0);
    idle(2);

    cur_req = "R10";
    issue(3'd2, cw(0, 0, 3, 0, 0), 0);
    issue(3'd0, cw(7, 0, 0, 0, 0), 32'hDEADBEEF);
    issue(3'd2, cw(0, 1, 4, 0, 0), 0);
    issue(3'd2, cw(0, 5, 7, 0, 0), 0);
    idle(4);
    issue(3'd1, cw(7, 0, 0, 0, 0), 0);
    idle(1);

    cur_req = "R3";
    issue(3'd2, cw(0, 1, 5, 0, 0), 0);
    idle(6);
    issue(3'd2, cw(0, 2, 4, 0, 0), 0);
    idle(2);

    cur_req = "R4";
    issue(3'd2, cw(0, 3, 0, 0, 0), 0);
    issue(3'd2, cw(0, 4, 0, 0, 0), 0);
    issue(3'd2, cw(0, 1, 5, 0, 0), 0);
    idle(2);
    issue(3'd2, cw(0, 3, 0, 0, 0), 0);
    idle(8);

    cur_req = "R5";
    issue(3'd2, cw(0, 2, 5, 0, 0), 0);
    idle(2);
    issue(3'd2, cw(0, 2, 8, 0, 0), 0);
    idle(9);
    issue(3'd2, cw(0, 4, 0, 0, 0), 0);
    idle(1);

    cur_req = "R6";
    issue(3'd2, cw(0, 5, 9, 0, 0), 0);
    idle(3);
    issue(3'd2, cw(0, 5, 11, 0, 0), 0);
    issue(3'd1, cw(9, 0, 0, 0, 0), 0);
    issue(3'd1, cw(11, 0, 0, 0, 0), 0);

    cur_req = "R7";
    issue(3'd2, cw(0, 9, 2, 0, 0), 0);
    issue(3'd2, cw(0, 15, 5, 0, 0), 0);
    issue(3'd6, cw(2, 0, 0, 0, 0), 32'h12345678);
    issue(3'd1, cw(2, 0, 0, 0, 0), 0);
    issue(3'd1, cw(5, 0, 0, 0, 0), 0);
    idle(2);

    cur_req = "R8";
    issue(3'd3, cw(0, 0, 0, 12, 0), 32'hC0DE0012);
    cmd_word = cw(0, 0, 0, 15, 1);
    issue(3'd3, cw(0, 0, 0, 15, 1), 32'h0F0F0F0F);
    wr_data = 32'hF0F0F0F0;
    step();
    issue(3'd1, cw(12, 0, 0, 0, 0), 0);
    issue(3'd1, cw(15, 0, 0, 0, 0), 0);
    issue(3'd1, cw(0, 0, 0, 0, 0), 0);

    cur_req = "R9";
    issue(3'd4, cw(0, 0, 0, 2, 0), 0);
    issue(3'd4, cw(0, 0, 0, 15, 1), 0);
    idle(1);
    issue(3'd4, cw(0, 0, 0, 6, 1), 0);
    idle(2);

    finished = 1;
    summary();
    $finish;
  end
endmodule